// File: doc/BRIEF.md
# System Clock Source Selector and Divider

This block owns one 16-bit control word that decides where the system clock comes from and how far it is divided. Four clock sources exist: an internal oscillator, a low-speed oscillator, a high-speed oscillator and an external clock input. Each source is presented to the block as a tick strobe in the control clock domain. The output `sys_tick` pulses once per divided period of the source that is currently active. Which division ratios are legal depends on the source. The word also holds a second source/divider pair and an enable bit. When the enable bit is set, that second pair replaces the live selection when the chip wakes from sleep.

Software writes the word only while write protection is released. Any requested combination that is not legal is refused, and the previous legal setting stays. The block raises a start request for the source it is told to use. It moves to that source only after the source reports stable, and only at a divided-period boundary, so no shortened period ever appears on `sys_tick`. Until the switch happens, the old source keeps driving the output.

Top module: `sysclk_ctl`

## Requirements
- R1: The word reads as bit 15 wake enable, bits 13:12 wake divider code, bits 9:8 wake source code, bits 5:4 divider code and bits 1:0 source code. Every other bit reads 0.
- R2: After reset the word reads 0x0020 (source 0, divider code 2). The active selection is source 0 with divider code 2, so `sys_tick` has a period of 4 source ticks.
- R3: A write changes the word only when `wr_en` and `wprot_off` are both 1. A write with `wprot_off` = 0 leaves `rd_data` and the active selection unchanged.
- R4: Source codes are 0 internal, 1 low-speed, 2 high-speed and 3 external. The active pair always divides as follows:
  - Source 0: codes 0/1/2/3 give 1/2/4/8.
  - Source 2: codes 0/1/2/3 give 1/2/8/16.
  - Source 1: codes 0/1 give 1/2.
  - Source 3: code 0 gives 1.
- R5: A write whose source/divider pair is reserved leaves the live source and divider fields at their previous legal values. The wake fields in that same write are still stored.
- R6: `osc_req` has bit n set exactly when source n is the requested source (bits 1:0 of the word) or the active source. No other bit is set.
- R7: The active selection moves to a new requested pair only while `src_stable` of the requested source is 1. Until it moves, `sys_tick` keeps the period of the old selection.
- R8: A switch happens at a divided-period boundary and restarts the divider. The first `sys_tick` comes a full new period after the active selection changes.
- R9: When `wake_evt` is 1 and the wake enable bit is 1, the wake source and divider codes are copied into the live fields. A reserved wake pair is not copied. A wake reload takes precedence over a write in the same cycle.
- R10: When `wake_evt` is 1 and the wake enable bit is 0, the word and the active selection stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| wprot_off | input | 1 | 1 while write protection is released |
| rd_data | output | 16 | Current control word |
| wake_evt | input | 1 | One-cycle wake-from-sleep event |
| src_stable | input | 4 | Per-source stable flag |
| src_tick | input | 4 | Per-source tick strobe |
| osc_req | output | 4 | Per-source start request |
| act_src | output | 2 | Source code now driving the output |
| act_div | output | 2 | Divider code now in use |
| sys_tick | output | 1 | One pulse per divided period |

## Verification
The properties assume that `src_stable` and `src_tick` are clean, single-bit-per-source levels that change only between control clock edges. They also assume that `wake_evt` is never left at X once reset is released. The bench drives every input at falling edges and holds `src_tick` high on all four sources, so a divided period is an exact number of control cycles. It also keeps `wake_evt` and the write strobe in separate cycles, which keeps the hold properties unambiguous about what caused a change in `rd_data`.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   localparam int unsigned SRC_CNT   = 4;
   localparam int unsigned CODE_W    = 2;
   localparam int unsigned WORD_W    = 16;
   localparam logic [WORD_W-1:0] WORD_RESET = 16'h0020;

   typedef enum logic [CODE_W-1:0] {
      SRC_INT  = 2'd0,
      SRC_LOW  = 2'd1,
      SRC_HIGH = 2'd2,
      SRC_EXT  = 2'd3
   } src_e;

   // legal source/divider pairs
   function automatic logic pair_ok(input logic [CODE_W-1:0] s, input logic [CODE_W-1:0] d);
      logic ok;
      case (s)
         SRC_LOW: ok = (d <= 2'd1);
         SRC_EXT: ok = (d == 2'd0);
         default: ok = 1'b1;
      endcase
      return ok;
   endfunction

   // log2 of the division ratio for a legal pair
   function automatic logic [2:0] ratio_lg(input logic [CODE_W-1:0] s, input logic [CODE_W-1:0] d);
      logic [2:0] lg;
      if (s == SRC_HIGH) begin
         case (d)
            2'd0:    lg = 3'd0;
            2'd1:    lg = 3'd1;
            2'd2:    lg = 3'd3;
            default: lg = 3'd4;
         endcase
      end else begin
         lg = {1'b0, d};
      end
      return lg;
   endfunction

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
   import sysclk_pkg::*;
#(
   parameter bit WAKE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              wprot_off,
   input  logic              wake_evt,
   output logic [WORD_W-1:0] rd_data,
   output logic [CODE_W-1:0] cfg_src,
   output logic [CODE_W-1:0] cfg_div
);

   logic              wk_mode;
   logic [CODE_W-1:0] wk_src;
   logic [CODE_W-1:0] wk_div;
   logic              wr_ok;
   logic              wake_go;
   logic [CODE_W-1:0] wr_src;
   logic [CODE_W-1:0] wr_div;
   logic              wr_unused;

   assign wr_ok  = wr_en & wprot_off;
   assign wr_src = wr_data[1:0];
   assign wr_div = wr_data[5:4];
   assign wr_unused = ^{wr_data[14], wr_data[11:10], wr_data[7:6], wr_data[3:2]};

   generate
      if (WAKE_EN) begin : g_wake
         assign wake_go = wake_evt & wk_mode & pair_ok(wk_src, wk_div);
      end else begin : g_nowake
         logic wake_unused;
         assign wake_unused = wake_evt;
         assign wake_go     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_src <= WORD_RESET[1:0];
         cfg_div <= WORD_RESET[5:4];
         wk_src  <= WORD_RESET[9:8];
         wk_div  <= WORD_RESET[13:12];
         wk_mode <= WORD_RESET[15];
      end else begin
         if (wake_go) begin
            cfg_src <= wk_src;
            cfg_div <= wk_div;
         end else if (wr_ok && pair_ok(wr_src, wr_div)) begin
            cfg_src <= wr_src;
            cfg_div <= wr_div;
         end
         if (wr_ok) begin
            wk_mode <= wr_data[15];
            wk_div  <= wr_data[13:12];
            wk_src  <= wr_data[9:8];
         end
      end
   end

   assign rd_data = {wk_mode, 1'b0, wk_div, 2'b00, wk_src, 2'b00, cfg_div, 2'b00, cfg_src};

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
   import sysclk_pkg::*;
#(
   parameter int unsigned NSRC = SRC_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] cfg_src,
   input  logic [CODE_W-1:0] cfg_div,
   input  logic [NSRC-1:0]   src_stable,
   input  logic              at_boundary,
   output logic [CODE_W-1:0] act_src,
   output logic [CODE_W-1:0] act_div,
   output logic              switch_now,
   output logic [NSRC-1:0]   osc_req
);

   logic pending;

   assign pending    = (cfg_src != act_src) || (cfg_div != act_div);
   assign switch_now = pending & src_stable[cfg_src] & at_boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src <= WORD_RESET[1:0];
         act_div <= WORD_RESET[5:4];
      end else if (switch_now) begin
         act_src <= cfg_src;
         act_div <= cfg_div;
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_req
      assign osc_req[i] = (cfg_src == CODE_W'(i)) || (act_src == CODE_W'(i));
   end

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
   import sysclk_pkg::*;
#(
   parameter int unsigned NSRC     = SRC_CNT,
   parameter int unsigned MAX_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] act_src,
   input  logic [CODE_W-1:0] act_div,
   input  logic [NSRC-1:0]   src_tick,
   input  logic              switch_now,
   output logic              at_boundary,
   output logic              sys_tick
);

   localparam int unsigned CNT_W = MAX_LOG2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   lim_w;
   logic [CNT_W-1:0] lim;
   logic             tick_sel;

   assign tick_sel    = src_tick[act_src];
   assign lim_w       = ((CNT_W+1)'(1) << ratio_lg(act_src, act_div)) - (CNT_W+1)'(1);
   assign lim         = lim_w[CNT_W-1:0];
   assign at_boundary = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sys_tick <= 1'b0;
      end else if (switch_now) begin
         cnt      <= '0;
         sys_tick <= 1'b0;
      end else if (tick_sel) begin
         if (cnt == lim) begin
            cnt      <= '0;
            sys_tick <= 1'b1;
         end else begin
            cnt      <= cnt + 1'b1;
            sys_tick <= 1'b0;
         end
      end else begin
         sys_tick <= 1'b0;
      end
   end

endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
   import sysclk_pkg::*;
#(
   parameter int unsigned NSRC     = SRC_CNT,
   parameter int unsigned MAX_LOG2 = 4,
   parameter bit          WAKE_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   input  logic        wprot_off,
   output logic [15:0] rd_data,
   input  logic        wake_evt,
   input  logic [3:0]  src_stable,
   input  logic [3:0]  src_tick,
   output logic [3:0]  osc_req,
   output logic [1:0]  act_src,
   output logic [1:0]  act_div,
   output logic        sys_tick
);

   generate
      if (NSRC != 4) begin : g_bad_nsrc
         $error("sysclk_ctl: NSRC must be 4 to match the 2-bit source code");
      end
      if (MAX_LOG2 < 4) begin : g_bad_log2
         $error("sysclk_ctl: MAX_LOG2 must cover divide-by-16");
      end
   endgenerate

   logic [CODE_W-1:0] cfg_src;
   logic [CODE_W-1:0] cfg_div;
   logic              at_boundary;
   logic              switch_now;

   sysclk_regs #(.WAKE_EN(WAKE_EN)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wprot_off (wprot_off),
      .wake_evt  (wake_evt),
      .rd_data   (rd_data),
      .cfg_src   (cfg_src),
      .cfg_div   (cfg_div)
   );

   sysclk_switch #(.NSRC(NSRC)) u_switch (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_src     (cfg_src),
      .cfg_div     (cfg_div),
      .src_stable  (src_stable),
      .at_boundary (at_boundary),
      .act_src     (act_src),
      .act_div     (act_div),
      .switch_now  (switch_now),
      .osc_req     (osc_req)
   );

   sysclk_div #(.NSRC(NSRC), .MAX_LOG2(MAX_LOG2)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_src     (act_src),
      .act_div     (act_div),
      .src_tick    (src_tick),
      .switch_now  (switch_now),
      .at_boundary (at_boundary),
      .sys_tick    (sys_tick)
   );

endmodule

// File: rtl/sysclk_ctl_chk.sv
module sysclk_ctl_chk
   import sysclk_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wprot_off,
   input logic [15:0] rd_data,
   input logic        wake_evt,
   input logic [3:0]  src_stable,
   input logic [3:0]  osc_req,
   input logic [1:0]  act_src,
   input logic [1:0]  act_div
);

   logic [3:0] stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= '0;
      else        stb_q <= src_stable;
   end

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~16'hB333) == 16'h0000);  // R1

   AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && !wprot_off && !wake_evt) |-> $stable(rd_data));  // R3

   AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok(act_src, act_div));  // R4

   AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ok(rd_data[1:0], rd_data[5:4]));  // R5

   AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      osc_req[rd_data[1:0]] && osc_req[act_src] && ($countones(osc_req) <= 2));  // R6

   AST_SWITCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({act_src, act_div}) |-> stb_q[act_src]);  // R7

   AST_WAKE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wake_evt && !rd_data[15] && !(wr_en && wprot_off)) |-> $stable(rd_data));  // R10

endmodule

bind sysclk_ctl sysclk_ctl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wprot_off  (wprot_off),
   .rd_data    (rd_data),
   .wake_evt   (wake_evt),
   .src_stable (src_stable),
   .osc_req    (osc_req),
   .act_src    (act_src),
   .act_div    (act_div)
);

// File: tb/sysclk_ctl_tb.sv
`timescale 1ns/1ps
module sysclk_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wprot_off = 1'b0;
   logic [15:0] rd_data;
   logic        wake_evt = 1'b0;
   logic [3:0]  src_stable = 4'hF;
   logic [3:0]  src_tick = 4'hF;
   logic [3:0]  osc_req;
   logic [1:0]  act_src;
   logic [1:0]  act_div;
   logic        sys_tick;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sysclk_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wprot_off(wprot_off), .rd_data(rd_data), .wake_evt(wake_evt),
      .src_stable(src_stable), .src_tick(src_tick), .osc_req(osc_req),
      .act_src(act_src), .act_div(act_div), .sys_tick(sys_tick)
   );

   // {write data, expected source, expected divider, expected period}
   localparam logic [24:0] VEC [0:8] = '{
      {16'h0000, 2'd0, 2'd0, 5'd1},
      {16'h0030, 2'd0, 2'd3, 5'd8},
      {16'h0032, 2'd2, 2'd3, 5'd16},
      {16'h0022, 2'd2, 2'd2, 5'd8},
      {16'h0011, 2'd1, 2'd1, 5'd2},
      {16'h0021, 2'd1, 2'd1, 5'd2},
      {16'h0003, 2'd3, 2'd0, 5'd1},
      {16'h0013, 2'd3, 2'd0, 5'd1},
      {16'h0020, 2'd0, 2'd2, 5'd4}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] d, input logic wp);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wprot_off = wp;
      @(negedge clk);
      wr_en = 1'b0; wprot_off = 1'b0;
   endtask

   task automatic do_wake();
      @(negedge clk);
      wake_evt = 1'b1;
      @(negedge clk);
      wake_evt = 1'b0;
   endtask

   task automatic wait_act(input logic [1:0] s, input logic [1:0] d);
      for (int i = 0; i < 64; i++) begin
         if (act_src == s && act_div == d) break;
         @(negedge clk);
      end
   endtask

   task automatic period(output int p);
      int n;
      n = 0;
      while (!sys_tick && n < 64) begin @(negedge clk); n++; end
      p = 0;
      do begin @(negedge clk); p++; end while (!sys_tick && p < 64);
   endtask

   initial begin
      int p;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset word", rd_data, 16'h0020);
      chk("R2 reset active", {act_src, act_div}, 4'b0010);
      chk("R6 reset request", osc_req, 4'b0001);
      period(p);
      chk("R2 reset period", p, 4);

      for (int v = 0; v < 9; v++) begin
         do_write(VEC[v][24:9], 1'b1);
         chk("R5 readback", rd_data, {10'b0, VEC[v][6:5], 2'b00, VEC[v][8:7]});
         wait_act(VEC[v][8:7], VEC[v][6:5]);
         chk("R4 active", {act_src, act_div}, {VEC[v][8:7], VEC[v][6:5]});
         period(p);
         chk("R4 period", p, VEC[v][4:0]);
      end

      do_write(16'h0011, 1'b0);
      repeat (20) @(negedge clk);
      chk("R3 protected word", rd_data, 16'h0020);
      chk("R3 protected active", {act_src, act_div}, 4'b0010);

      do_write(16'hFFFF, 1'b1);
      chk("R1 reserved bits", rd_data, 16'hB320);
      repeat (20) @(negedge clk);
      chk("R5 reserved kept", {act_src, act_div}, 4'b0010);

      do_write(16'h9200, 1'b1);
      chk("R9 setup", rd_data, 16'h9200);
      wait_act(2'd0, 2'd0);
      do_wake();
      chk("R9 reload word", rd_data, 16'h9212);
      wait_act(2'd2, 2'd1);
      chk("R9 reload active", {act_src, act_div}, 4'b1001);
      period(p);
      chk("R9 reload period", p, 2);

      do_write(16'hB110, 1'b1);
      do_wake();
      chk("R9 reserved wake pair", rd_data, 16'hB110);

      do_write(16'h3300, 1'b1);
      wait_act(2'd0, 2'd0);
      do_wake();
      chk("R10 word", rd_data, 16'h3300);
      repeat (20) @(negedge clk);
      chk("R10 active", {act_src, act_div}, 4'b0000);

      src_stable = 4'b1011;
      do_write(16'h0022, 1'b1);
      chk("R6 request both", osc_req, 4'b0101);
      repeat (40) @(negedge clk);
      chk("R7 held", {act_src, act_div}, 4'b0000);
      period(p);
      chk("R7 old period", p, 1);
      @(negedge clk);
      src_stable = 4'hF;
      for (int i = 0; i < 64; i++) begin
         if (act_src == 2'd2) break;
         @(negedge clk);
      end
      k = 0;
      do begin @(negedge clk); k++; end while (!sys_tick && k < 64);
      chk("R8 first period", k, 8);
      chk("R6 request after", osc_req, 4'b0100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule